// File: doc/BRIEF.md
# Regulator Undervoltage Fault Interrupt Controller

This block watches the undervoltage flags of four voltage regulators and turns them into software-visible events. A raw flag must stay high for a programmable number of consecutive clock cycles before it is taken as a real fault, so short dips during current surges are discarded. The first cycle a channel's fault becomes confirmed sets a sticky status bit. Software reading the status register clears every bit it reads.

Each status bit can be masked. The single interrupt output is the OR of all status bits whose mask bit is 0. Each channel also has a 2-bit action field. On a confirmed fault event that field can request that this regulator be switched off, or that the whole system shut down. These requests are sticky until software writes the field back to zero. The interrupt is raised whatever the action field holds.

Software sees everything through a small register port. Reads are combinational on the selected address. Writes and clear-on-read take effect at the clock edge.

Top module: `vreg_fault_irq`

## Requirements
- R1: After synchronous reset, the status bits, mask bits and all four action fields read 0, and `irq_o`, `reg_off_o` and `sys_off_o` are low.
- R2: A channel's raw flag counts as a confirmed fault only after it has been sampled high on `PERSIST_CYCLES` consecutive clock edges. Any low sample restarts the count, so a shorter pulse never sets status.
- R3: A status bit is set once, on the first cycle its fault becomes confirmed. A fault that is still confirmed after that bit is read does not set it again until the flag has dropped and been confirmed anew.
- R4: Status is at address 0, with channel k at bit 8+k (channel 3 at bit 11, channel 0 at bit 8). A read of address 0 clears all status bits at that edge. Reads of other addresses leave status unchanged, and writes to address 0 are ignored.
- R5: If a channel's fault becomes confirmed in the same cycle as a status read, that channel's bit is set afterwards and is not lost.
- R6: The mask is at address 1, with the same bit positions as status. A mask bit of 1 keeps that channel out of `irq_o`, but its status bit is still recorded.
- R7: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0.
- R8: The action field of channel k is bits 15:14 of address 2+k. The value 01 sets `reg_off_o[k]` on that channel's confirmed fault event.
- R9: An action value of 10, or the reserved value 11, sets `sys_off_o` on that channel's confirmed fault event.
- R10: An action value of 00 requests nothing on a fault, and the status bit and interrupt are raised regardless of the action value.
- R11: `reg_off_o[k]`, and channel k's share of `sys_off_o`, stay asserted until reset or until 00 is written to channel k's action field. `sys_off_o` drops only when no channel still holds a shutdown request. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_raw_i | input | 4 | Raw undervoltage flags, bit k for channel k |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears status on address 0) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Combined unmasked fault interrupt |
| reg_off_o | output | 4 | Per-channel regulator disable request |
| sys_off_o | output | 1 | System shutdown request |

## Verification
The bench builds the block with `PERSIST_CYCLES` set to 5. This keeps each confirmation short enough that many faults, reads and action changes fit in a few hundred cycles. With that setting, a pulse of exactly one cycle less than the limit can be shown to be discarded. A status read can also be swept across the confirmation cycle to hit the read-versus-set coincidence. Overlapping faults on several channels then exercise the masking and the shutdown that several channels share.

// File: rtl/vfi_pkg.sv
package vfi_pkg;
    localparam int NCH     = 4;
    localparam int DW      = 16;
    localparam int AW      = 3;
    localparam int STAT_LO = 8;
    localparam int ACT_LO  = 14;

    localparam logic [AW-1:0] A_STAT = 3'd0;
    localparam logic [AW-1:0] A_MASK = 3'd1;
    localparam logic [AW-1:0] A_ACT0 = 3'd2;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_REGOFF = 2'b01,
        ACT_SYSOFF = 2'b10,
        ACT_RSVD   = 2'b11
    } fault_act_e;

    typedef struct packed {
        logic reg_off;
        logic sys_off;
    } act_req_t;

    function automatic act_req_t act_decode(input fault_act_e a);
        act_req_t r;
        r = '0;
        case (a)
            ACT_REGOFF: r.reg_off = 1'b1;
            ACT_SYSOFF: r.sys_off = 1'b1;
            ACT_RSVD:   r.sys_off = 1'b1;
            default:    r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [AW-1:0] act_addr(input int ch);
        return A_ACT0 + AW'(ch);
    endfunction
endpackage

// File: rtl/vfi_persist.sv
module vfi_persist
    import vfi_pkg::*;
#(
    parameter int PERSIST_CYCLES = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] raw_i,
    output logic [NCH-1:0] conf_o
);
    localparam int CW = $clog2(PERSIST_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PERSIST_CYCLES);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [CW-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst)
                cnt_q <= '0;
            else if (!raw_i[ch])
                cnt_q <= '0;
            else if (cnt_q != LIMIT)
                cnt_q <= cnt_q + 1'b1;
        end
        assign conf_o[ch] = (cnt_q == LIMIT);
    end

    // R2
    raw_low_drops_conf_chk: assert property (@(posedge clk) disable iff (rst)
        (raw_i != '0 || raw_i == '0) |=> ((conf_o & ~$past(raw_i)) == '0));
endmodule

// File: rtl/vfi_status.sv
module vfi_status
    import vfi_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] conf_i,
    input  logic           clr_i,
    output logic [NCH-1:0] rise_o,
    output logic [NCH-1:0] status_o
);
    logic [NCH-1:0] conf_q;
    logic [NCH-1:0] status_q;

    assign rise_o = conf_i & ~conf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            conf_q   <= '0;
            status_q <= '0;
        end else begin
            conf_q   <= conf_i;
            status_q <= rise_o | (clr_i ? '0 : status_q);
        end
    end

    assign status_o = status_q;

    // R3 R5
    rise_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
        (rise_o != '0) |=> ((status_q & $past(rise_o)) == $past(rise_o)));

    // R4
    read_clears_status_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && rise_o == '0) |=> (status_q == '0));
endmodule

// File: rtl/vfi_action.sv
module vfi_action
    import vfi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       rise_i,
    input  logic [NCH-1:0][1:0]  act_i,
    input  logic [NCH-1:0]       clr_i,
    output logic [NCH-1:0]       reg_off_o,
    output logic                 sys_off_o
);
    logic [NCH-1:0] dis_q;
    logic [NCH-1:0] sd_q;
    logic [NCH-1:0] dis_evt;
    logic [NCH-1:0] sd_evt;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        act_req_t req;
        assign req         = act_decode(fault_act_e'(act_i[ch]));
        assign dis_evt[ch] = rise_i[ch] & req.reg_off;
        assign sd_evt[ch]  = rise_i[ch] & req.sys_off;

        always_ff @(posedge clk) begin
            if (rst || clr_i[ch]) begin
                dis_q[ch] <= 1'b0;
                sd_q[ch]  <= 1'b0;
            end else begin
                if (dis_evt[ch]) dis_q[ch] <= 1'b1;
                if (sd_evt[ch])  sd_q[ch]  <= 1'b1;
            end
        end
    end

    assign reg_off_o = dis_q;
    assign sys_off_o = |sd_q;

    // R8
    regoff_event_chk: assert property (@(posedge clk) disable iff (rst)
        ((dis_evt & ~clr_i) != '0) |=> ((reg_off_o & $past(dis_evt & ~clr_i)) != '0));

    // R9
    sysoff_event_chk: assert property (@(posedge clk) disable iff (rst)
        ((sd_evt & ~clr_i) != '0) |=> sys_off_o);

    // R11
    action_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i != '0) |=> ((reg_off_o & $past(clr_i)) == '0));
endmodule

// File: rtl/vreg_fault_irq.sv
module vreg_fault_irq
    import vfi_pkg::*;
#(
    parameter int PERSIST_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    uv_raw_i,
    input  logic [2:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    output logic          irq_o,
    output logic [3:0]    reg_off_o,
    output logic          sys_off_o
);
    logic [NCH-1:0]      conf;
    logic [NCH-1:0]      rise;
    logic [NCH-1:0]      status;
    logic [NCH-1:0]      mask_q;
    logic [NCH-1:0][1:0] act_q;
    logic [NCH-1:0]      act_clr;
    logic                stat_rd;
    logic                unused_wbits;

    assign unused_wbits = ^{reg_wdata[13:12], reg_wdata[7:0]};
    assign stat_rd      = reg_rd && (reg_addr == A_STAT);

    vfi_persist #(.PERSIST_CYCLES(PERSIST_CYCLES)) persist_i (
        .clk(clk), .rst(rst), .raw_i(uv_raw_i), .conf_o(conf)
    );

    vfi_status status_i (
        .clk(clk), .rst(rst), .conf_i(conf), .clr_i(stat_rd),
        .rise_o(rise), .status_o(status)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (reg_wr && reg_addr == A_MASK)
            mask_q <= reg_wdata[STAT_LO +: NCH];
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_act
        logic hit;
        assign hit         = reg_wr && (reg_addr == act_addr(ch));
        assign act_clr[ch] = hit && (reg_wdata[ACT_LO +: 2] == ACT_NONE);
        always_ff @(posedge clk) begin
            if (rst)
                act_q[ch] <= ACT_NONE;
            else if (hit)
                act_q[ch] <= reg_wdata[ACT_LO +: 2];
        end
    end

    vfi_action action_i (
        .clk(clk), .rst(rst), .rise_i(rise), .act_i(act_q), .clr_i(act_clr),
        .reg_off_o(reg_off_o), .sys_off_o(sys_off_o)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STAT)
            reg_rdata[STAT_LO +: NCH] = status;
        else if (reg_addr == A_MASK)
            reg_rdata[STAT_LO +: NCH] = mask_q;
        else
            for (int ch = 0; ch < NCH; ch++)
                if (reg_addr == act_addr(ch))
                    reg_rdata[ACT_LO +: 2] = act_q[ch];
    end

    assign irq_o = |(status & ~mask_q);

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |-> !irq_o);
endmodule

// File: tb/vreg_fault_irq_tb.sv
module vreg_fault_irq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  uv_raw_i = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_o;
    logic [3:0]  reg_off_o;
    logic        sys_off_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    vreg_fault_irq #(.PERSIST_CYCLES(P)) dut_i (
        .clk(clk), .rst(rst), .uv_raw_i(uv_raw_i), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o), .reg_off_o(reg_off_o),
        .sys_off_o(sys_off_o)
    );

    int vectors = 0;
    int fails = 0;
    string tag = "R1";
    logic [15:0] last_rd;

    // behavioural reference state
    int         m_run [4];
    bit         m_prev [4];
    bit [3:0]   m_stat, m_mask, m_dis, m_sd;
    bit [1:0]   m_act [4];

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_run[c] = 0; m_prev[c] = 0; m_act[c] = 0;
        end
        m_stat = 0; m_mask = 0; m_dis = 0; m_sd = 0;
    endtask

    function automatic logic [15:0] model_read(input logic [2:0] a);
        logic [15:0] v = '0;
        if (a == 0) v[11:8] = m_stat;
        else if (a == 1) v[11:8] = m_mask;
        else if (a <= 5) v[15:14] = m_act[a-2];
        return v;
    endfunction

    task automatic cmp(input string what, input string rq, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] raw, input logic wr, input logic rd,
                        input logic [2:0] a, input logic [15:0] d);
        uv_raw_i = raw; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
        #1;
        last_rd = reg_rdata;
        if (!rst) begin
            cmp("rdata", tag, reg_rdata, model_read(a));
            cmp("irq (R7)", tag, {15'b0, irq_o}, {15'b0, |(m_stat & ~m_mask)});
            cmp("reg_off (R8)", tag, {12'b0, reg_off_o}, {12'b0, m_dis});
            cmp("sys_off (R9)", tag, {15'b0, sys_off_o}, {15'b0, |m_sd});
        end
        if (rst) model_reset();
        else begin
            for (int c = 0; c < 4; c++) begin
                bit conf, rise, aclr;
                conf = (m_run[c] >= P);
                rise = conf && !m_prev[c];
                if (rise) m_stat[c] = 1;
                else if (rd && a == 0) m_stat[c] = 0;
                aclr = wr && (a == 3'(c + 2)) && (d[15:14] == 0);
                if (aclr) begin m_dis[c] = 0; m_sd[c] = 0; end
                else if (rise) begin
                    if (m_act[c] == 1) m_dis[c] = 1;
                    if (m_act[c] >= 2) m_sd[c] = 1;
                end
                m_prev[c] = conf;
                m_run[c] = raw[c] ? ((m_run[c] < 1000) ? m_run[c] + 1 : m_run[c]) : 0;
                if (wr && a == 3'(c + 2)) m_act[c] = d[15:14];
            end
            if (wr && a == 1) m_mask = d[11:8];
        end
        @(negedge clk);
    endtask

    task automatic idle(input logic [3:0] raw, input int n);
        for (int i = 0; i < n; i++) step(raw, 0, 0, 3'd7, 16'h0);
    endtask

    task automatic rd(input logic [3:0] raw, input logic [2:0] a);
        step(raw, 0, 1, a, 16'h0);
    endtask

    task automatic wr(input logic [3:0] raw, input logic [2:0] a, input logic [15:0] d);
        step(raw, 1, 0, a, d);
    endtask

    task automatic lit(input string rq, input logic [15:0] exp);
        cmp("literal read", rq, last_rd, exp);
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        step(4'h0, 0, 0, 0, 0);
        step(4'h0, 0, 0, 0, 0);
        rst = 1'b0;
        step(4'h0, 0, 0, 0, 0);

        tag = "R1";
        rd(4'h0, 3'd0); lit("R1", 16'h0000);
        rd(4'h0, 3'd1); lit("R1", 16'h0000);
        for (int c = 0; c < 4; c++) begin rd(4'h0, 3'(c + 2)); lit("R1", 16'h0000); end
        rd(4'h0, 3'd6); lit("R11", 16'h0000);

        tag = "R2";
        idle(4'h1, P - 1); idle(4'h0, 4);
        rd(4'h0, 3'd0); lit("R2", 16'h0000);
        idle(4'h1, P - 2); idle(4'h0, 1); idle(4'h1, P - 1); idle(4'h0, 3);
        rd(4'h0, 3'd0); lit("R2", 16'h0000);

        tag = "R3";
        idle(4'h1, P + 3);
        rd(4'h1, 3'd0); lit("R3", 16'h0100);
        idle(4'h1, 3);
        rd(4'h1, 3'd0); lit("R3", 16'h0000);
        wr(4'h1, 3'd0, 16'h0F00);
        rd(4'h1, 3'd0); lit("R4", 16'h0000);
        idle(4'h0, 2);

        tag = "R5";
        for (int off = -1; off <= 2; off++) begin
            idle(4'h2, P + off);
            rd(4'h2, 3'd0);
            idle(4'h2, 2);
            rd(4'h0, 3'd0);
            idle(4'h0, 2);
        end

        tag = "R6";
        wr(4'h0, 3'd1, 16'h0400);
        rd(4'h0, 3'd1); lit("R6", 16'h0400);
        idle(4'h4, P + 3);
        rd(4'h4, 3'd3); // non-status read keeps status
        rd(4'h4, 3'd0); lit("R6", 16'h0400);
        idle(4'h0, 2);

        tag = "R7";
        idle(4'hC, P + 3);
        idle(4'h0, 2);
        rd(4'h0, 3'd0); lit("R7", 16'h0C00);
        wr(4'h0, 3'd1, 16'h0000);
        idle(4'h0, 2);

        tag = "R8";
        wr(4'h0, 3'd3, 16'h4000);
        rd(4'h0, 3'd3); lit("R8", 16'h4000);
        idle(4'h2, P + 3);
        idle(4'h0, 3);

        tag = "R10";
        idle(4'h1, P + 3);
        idle(4'h0, 2);
        rd(4'h0, 3'd0);

        tag = "R9";
        wr(4'h0, 3'd4, 16'h8000);
        wr(4'h0, 3'd5, 16'hC000);
        idle(4'h4, P + 3);
        idle(4'h0, 2);
        idle(4'h8, P + 3);
        idle(4'h0, 2);

        tag = "R11";
        wr(4'h0, 3'd3, 16'h3FFF);
        idle(4'h0, 2);
        wr(4'h0, 3'd4, 16'h0000);
        idle(4'h0, 2);
        wr(4'h0, 3'd5, 16'h0000);
        idle(4'h0, 3);
        rd(4'h0, 3'd0);
        idle(4'hF, P + 4);
        idle(4'h0, 3);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule